// File: doc/BRIEF.md
# I2C Read-Data Substitution Interposer

The interposer sits in series with the SDA line between one I2C master and one slave. SCL is not cut. It passes straight from the master to the slave, and the block only listens to it. SDA is split into a master-side pin and a slave-side pin, and each pin is modelled as an input plus an open-drain output enable (enable high pulls the line low).

From synchronized copies of SCL and the master-side SDA, a phase tracker follows every byte and acknowledge slot. It steers the SDA forwarding direction bit slot by bit, through a purely combinational path, so the block adds no delay of its own and never stretches the clock.

The block remembers the register number that the master writes just before a read. A register-select write is START, address+W, one byte, STOP. The following read is START, address+R, data, STOP. A host-side load port fills a small table of {register, replacement byte} pairs. When the first data byte of a read belongs to a register in the table, the block drives the replacement byte toward the master in place of the slave's data. The slave side is left untouched.

Top module: `sda_splice_top`

## Requirements
- R1: After reset both SDA output enables are low, and no substitution is pending.
- R2: During address bits, write-data bits and the master's ACK/NACK slot after a read byte, the slave-side SDA line follows the master-side line, and the master-side enable stays low.
- R3: During the slave's ACK slot and during read data bits, the master-side SDA line follows the slave-side line, and the slave-side enable stays low.
- R4: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are detected on two-flop synchronized pins. A START that follows a STOP after only a few bus-clock-free microseconds is tracked as a new transaction.
- R5: The register number is taken from a write transaction (R/W bit, the LSB of the address byte, equal to 0) that ends in STOP after exactly one data byte. A write that ends after any other number of data bytes clears the held register number.
- R6: If a register number is held and the table has an entry for it, the first read data byte seen by the master is the entry's byte, sent MSB first. The slave-side line still carries the slave's own data.
- R7: Only the first data byte of a read transaction may be replaced. Later bytes of the same read, after a master ACK (0), are forwarded unchanged.
- R8: The held register number is used up when an address+R byte is acknowledged. A second read with no new register-select write passes the slave's data.
- R9: A one-cycle load strobe writes {register, byte} into the table. A load for a register already present replaces that entry's byte.
- R10: The table holds 16 entries. A load of a new register when the table is full is ignored, and the existing entries stay in use.
- R11: A START in any phase returns the tracker to the address phase, and a STOP in any phase returns it to idle. The next transaction is then handled correctly.
- R12: While a replacement byte is being driven, the master-side enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, far faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL as driven by the master (observed only) |
| sda_m_in | input | 1 | Master-side SDA line level |
| sda_m_oe | output | 1 | Pull master-side SDA low when high |
| sda_s_in | input | 1 | Slave-side SDA line level |
| sda_s_oe | output | 1 | Pull slave-side SDA low when high |
| ld_stb | input | 1 | One-cycle table load strobe |
| ld_reg | input | 8 | Register number of the entry being loaded |
| ld_val | input | 8 | Replacement byte of the entry being loaded |

## Verification
An SCL edge reaches the tracker three clocks after it reaches the pin: two synchronizer flops plus the edge register. The forwarding direction and any replacement bit therefore change three to four clocks after SCL falls, while a table load is usable one clock after its strobe. The bench holds each SCL phase for twenty clocks and compares both SDA lines against its own reference model halfway through each SCL-high phase, long after every such latency has settled. The bus lines themselves are resolved on the falling clock edge, so the sampled values never depend on ordering at the active edge.

// File: rtl/sda_splice_pkg.sv
package sda_splice_pkg;

    localparam int BYTE_W = 8;

    // Bus phase as seen by the tracker.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_WBYTE,
        PH_WACK,
        PH_RBYTE,
        PH_RACK,
        PH_WAITP
    } phase_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] rid;
        logic [BYTE_W-1:0] val;
    } sub_ent_t;

    // Phases in which the slave owns SDA.
    function automatic logic slave_owns(input phase_t p);
        return (p == PH_AACK) || (p == PH_WACK) || (p == PH_RBYTE);
    endfunction

endpackage

// File: rtl/sda_cond_detect.sv
module sda_cond_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_q, sda_q;
    logic scl_p, sda_p, scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[TOP-1:0], scl_raw};
            sda_q <= {sda_q[TOP-1:0], sda_raw};
            scl_p <= scl_q[TOP];
            sda_p <= sda_q[TOP];
        end
    end

    assign scl_s     = scl_q[TOP];
    assign sda_s     = sda_q[TOP];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/sda_phase_fsm.sv
module sda_phase_fsm
    import sda_splice_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output phase_t            phase,
    output logic              held_vld,
    output logic [BYTE_W-1:0] held_reg,
    output logic              rd_begin,
    output logic              rd_shift,
    output logic              rd_done
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] sh, cand;
    logic              rw, in_wr, mack;
    logic [1:0]        wr_bytes;

    assign rd_begin = scl_fall && (phase == PH_AACK) && rw;
    assign rd_shift = scl_fall && (phase == PH_RBYTE) && (bit_cnt != LAST_BIT);
    assign rd_done  = scl_fall && (phase == PH_RBYTE) && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            sh       <= '0;
            cand     <= '0;
            rw       <= 1'b0;
            in_wr    <= 1'b0;
            mack     <= 1'b1;
            wr_bytes <= '0;
            held_vld <= 1'b0;
            held_reg <= '0;
        end else if (start_det) begin
            phase    <= PH_ADDR;
            bit_cnt  <= '0;
            wr_bytes <= '0;
            in_wr    <= 1'b0;
        end else if (stop_det) begin
            phase <= PH_IDLE;
            in_wr <= 1'b0;
            if (in_wr) begin
                // STOP after one acknowledged byte: the SCL pulse of the
                // STOP itself may already have counted one bit.
                held_vld <= (wr_bytes == 2'd1) && (phase == PH_WBYTE) && (bit_cnt <= 4'd1);
                held_reg <= cand;
            end
        end else begin
            if (scl_rise) begin
                case (phase)
                    PH_ADDR, PH_WBYTE, PH_RBYTE: begin
                        if (bit_cnt != LAST_BIT) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    PH_RACK: mack <= sda_s;
                    default: ;
                endcase
            end
            if (scl_fall) begin
                case (phase)
                    PH_ADDR: begin
                        if (bit_cnt == LAST_BIT) begin
                            phase <= PH_AACK;
                            rw    <= sh[0];
                        end
                    end
                    PH_AACK: begin
                        bit_cnt <= '0;
                        if (rw) begin
                            phase    <= PH_RBYTE;
                            held_vld <= 1'b0;
                        end else begin
                            phase <= PH_WBYTE;
                            in_wr <= 1'b1;
                        end
                    end
                    PH_WBYTE: begin
                        if (bit_cnt == LAST_BIT) begin
                            phase <= PH_WACK;
                            if (wr_bytes == 2'd0) cand <= sh;
                            if (wr_bytes != 2'd3) wr_bytes <= wr_bytes + 2'd1;
                        end
                    end
                    PH_WACK: begin
                        phase   <= PH_WBYTE;
                        bit_cnt <= '0;
                    end
                    PH_RBYTE: begin
                        if (bit_cnt == LAST_BIT) phase <= PH_RACK;
                    end
                    PH_RACK: begin
                        bit_cnt <= '0;
                        phase   <= mack ? PH_WAITP : PH_RBYTE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sda_sub_table.sv
module sda_sub_table
    import sda_splice_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_stb,
    input  logic [BYTE_W-1:0] ld_reg,
    input  logic [BYTE_W-1:0] ld_val,
    input  logic [BYTE_W-1:0] lk_reg,
    output logic              lk_hit,
    output logic [BYTE_W-1:0] lk_val
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    sub_ent_t          ent [N_ENT];
    logic [N_ENT-1:0]  same_v, free_v, hit_v;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign same_v[g] = ent[g].vld && (ent[g].rid == ld_reg);
        assign free_v[g] = !ent[g].vld;
        assign hit_v[g]  = ent[g].vld && (ent[g].rid == lk_reg);
    end

    // Slot choice: matching entry first, else lowest free slot.
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (free_v[i]) begin
                wr_en  = 1'b1;
                wr_idx = IDX_W'(i);
            end
        end
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (same_v[i]) begin
                wr_en  = 1'b1;
                wr_idx = IDX_W'(i);
            end
        end
        wr_en = wr_en && ld_stb;
    end

    always_comb begin
        lk_hit = 1'b0;
        lk_val = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit_v[i]) begin
                lk_hit = 1'b1;
                lk_val = ent[i].val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENT; i++) ent[i] <= '0;
        end else if (wr_en) begin
            ent[wr_idx] <= '{vld: 1'b1, rid: ld_reg, val: ld_val};
        end
    end
endmodule

// File: rtl/sda_splice_top.sv
module sda_splice_top
    import sda_splice_pkg::*;
#(
    parameter int N_ENT       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_m_in,
    output logic              sda_m_oe,
    input  logic              sda_s_in,
    output logic              sda_s_oe,
    input  logic              ld_stb,
    input  logic [BYTE_W-1:0] ld_reg,
    input  logic [BYTE_W-1:0] ld_val
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    phase_t            phase;
    logic              held_vld, rd_begin, rd_shift, rd_done;
    logic [BYTE_W-1:0] held_reg, lk_val, sub_sh;
    logic              lk_hit, sub_on, dir_s2m;

    // Only the master-side pin is sampled: it always shows what the master sees.
    sda_cond_detect #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_m_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    sda_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .phase(phase), .held_vld(held_vld), .held_reg(held_reg),
        .rd_begin(rd_begin), .rd_shift(rd_shift), .rd_done(rd_done)
    );

    sda_sub_table #(.N_ENT(N_ENT)) u_tab (
        .clk(clk), .rst(rst), .ld_stb(ld_stb), .ld_reg(ld_reg),
        .ld_val(ld_val), .lk_reg(held_reg), .lk_hit(lk_hit), .lk_val(lk_val)
    );

    // Replacement shifter advances on SCL falls, so bits move only while SCL is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            sub_on <= 1'b0;
            sub_sh <= '0;
        end else if (start_det || stop_det || rd_done) begin
            sub_on <= 1'b0;
        end else if (rd_begin) begin
            sub_on <= held_vld && lk_hit;
            sub_sh <= lk_val;
        end else if (rd_shift) begin
            sub_sh <= {sub_sh[BYTE_W-2:0], 1'b0};
        end
    end

    assign dir_s2m  = slave_owns(phase);
    assign sda_s_oe = !dir_s2m && !sda_m_in;
    assign sda_m_oe = dir_s2m && (sub_on ? !sub_sh[BYTE_W-1] : !sda_s_in);
endmodule

// File: rtl/sda_splice_chk.sv
module sda_splice_chk
    import sda_splice_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   scl_in,
    input logic   sda_m_oe,
    input logic   sda_s_oe,
    input logic   start_det,
    input logic   stop_det,
    input phase_t phase,
    input logic   sub_on,
    input logic   held_vld,
    input logic   rd_begin
);
    // R2/R3: only one side is ever pulled by the block
    p_one_side_r3: assert property (@(posedge clk) disable iff (rst)
        !(sda_m_oe && sda_s_oe));

    // R6: the slave side is never driven during read data
    p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RBYTE) |-> !sda_s_oe);

    p_start_addr_r11: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (phase == PH_ADDR));

    p_stop_idle_r4: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (phase == PH_IDLE));

    p_sub_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        (sub_on && $past(sub_on) && scl_in && $past(scl_in)) |-> $stable(sda_m_oe));

    p_held_consume_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(held_vld) |-> ($past(rd_begin) || $past(stop_det)));
endmodule

bind sda_splice_top sda_splice_chk u_chk (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_m_oe(sda_m_oe),
    .sda_s_oe(sda_s_oe), .start_det(start_det), .stop_det(stop_det),
    .phase(phase), .sub_on(sub_on), .held_vld(held_vld), .rd_begin(rd_begin)
);

// File: tb/sda_splice_top_tb_top.sv
`timescale 1ns/1ps
module sda_splice_top_tb_top;
    localparam int Q        = 20;
    localparam int WD_LIMIT = 150000;
    localparam logic [7:0] ADDR_W = 8'h50;
    localparam logic [7:0] ADDR_R = 8'h51;
    localparam int TAB_CAP  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0, s_low = 1'b0;
    logic m_line = 1'b1, s_line = 1'b1;
    logic ld_stb = 1'b0;
    logic [7:0] ld_reg = '0, ld_val = '0;
    logic sda_m_oe, sda_s_oe;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model
    logic [7:0] tab_reg[$];
    logic [7:0] tab_val[$];
    bit         held_v = 0;
    logic [7:0] held_r = '0;

    always #2 clk = ~clk;

    // wired-AND bus lines, resolved away from the active edge
    always @(negedge clk) begin
        m_line <= !(m_low || sda_m_oe);
        s_line <= !(s_low || sda_s_oe);
    end

    sda_splice_top dut_i (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_m_in(m_line),
        .sda_m_oe(sda_m_oe), .sda_s_in(s_line), .sda_s_oe(sda_s_oe),
        .ld_stb(ld_stb), .ld_reg(ld_reg), .ld_val(ld_val)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // one SCL period, entered and left with SCL low
    task automatic slot(input logic mb, input logic sb, input logic em, input logic es, input string tag);
        tick(2);
        m_low = !mb;
        s_low = !sb;
        tick(Q);
        scl = 1'b1;
        tick(Q / 2);
        chk(tag, "master line", m_line, em);
        chk(tag, "slave line", s_line, es);
        tick(Q / 2);
        scl = 1'b0;
    endtask

    task automatic do_start(input string tag);
        m_low = 1'b0;
        s_low = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b1;
        tick(Q / 2);
        chk(tag, "start seen at slave", s_line, 1'b0);
        tick(Q / 2);
        scl = 1'b0;
    endtask

    // leaves SCL high with only a short idle before the next START
    task automatic do_stop(input string tag);
        tick(2);
        m_low = 1'b1;
        s_low = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_low = 1'b0;
        tick(Q / 2);
        chk(tag, "stop seen at slave", s_line, 1'b1);
    endtask

    task automatic wbyte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) slot(b[i], 1'b1, b[i], b[i], tag);
        slot(1'b1, 1'b0, 1'b0, 1'b0, "R3");   // slave ACK reaches master
    endtask

    task automatic rbyte(input logic [7:0] d, input logic [7:0] e, input bit ack, input string tag);
        for (int i = 7; i >= 0; i--) slot(1'b1, d[i], e[i], d[i], tag);
        slot(!ack, 1'b1, !ack, !ack, "R2");  // master ACK/NACK reaches slave
    endtask

    function automatic int tab_find(input logic [7:0] r);
        for (int i = 0; i < tab_reg.size(); i++) if (tab_reg[i] == r) return i;
        return -1;
    endfunction

    task automatic load(input logic [7:0] r, input logic [7:0] v);
        int k;
        ld_stb = 1'b1;
        ld_reg = r;
        ld_val = v;
        tick(1);
        ld_stb = 1'b0;
        k = tab_find(r);
        if (k >= 0) tab_val[k] = v;
        else if (tab_reg.size() < TAB_CAP) begin
            tab_reg.push_back(r);
            tab_val.push_back(v);
        end
        tick(1);
    endtask

    task automatic wr_reg(input logic [7:0] r);
        do_start("R4");
        wbyte(ADDR_W, "R2");
        wbyte(r, "R2");
        do_stop("R4");
        held_v = 1;
        held_r = r;
    endtask

    task automatic wr_regdat(input logic [7:0] r, input logic [7:0] d);
        do_start("R4");
        wbyte(ADDR_W, "R2");
        wbyte(r, "R2");
        wbyte(d, "R2");
        do_stop("R4");
        held_v = 0;
    endtask

    task automatic rd(input int n, input logic [7:0] d0, input logic [7:0] d1, input string tag);
        logic [7:0] e0;
        int k;
        e0 = d0;
        k = tab_find(held_r);
        if (held_v && k >= 0) e0 = tab_val[k];
        held_v = 0;
        do_start("R4");
        wbyte(ADDR_R, "R2");
        rbyte(d0, e0, n > 1, tag);
        if (n > 1) rbyte(d1, d1, 0, "R7");
        do_stop("R4");
    endtask

    initial begin
        tick(10);
        rst = 1'b0;
        tick(4);
        chk("R1", "master oe after reset", sda_m_oe, 1'b0);
        chk("R1", "slave oe after reset", sda_s_oe, 1'b0);

        wr_regdat(8'h12, 8'h55);                 // R2 plain write
        wr_reg(8'h12); rd(1, 8'hA5, 8'h00, "R3"); // no entry: pass-through

        load(8'h12, 8'h3C);
        wr_reg(8'h12); rd(1, 8'hA5, 8'h00, "R6"); // replaced by 3C

        load(8'h12, 8'hC3);                      // R9 overwrite
        wr_reg(8'h12); rd(1, 8'h0F, 8'h00, "R9");

        rd(1, 8'h5A, 8'h00, "R8");               // held register used up

        wr_reg(8'h12); rd(2, 8'h11, 8'h22, "R7"); // only first byte replaced

        wr_reg(8'h12); wr_regdat(8'h12, 8'h99);  // R5 two-byte write clears
        rd(1, 8'h6B, 8'h00, "R5");

        // R11: unexpected START inside a write byte
        do_start("R11");
        wbyte(ADDR_W, "R11");
        for (int i = 0; i < 4; i++) slot(1'b0, 1'b1, 1'b0, 1'b0, "R11");
        do_start("R11");
        wbyte(ADDR_W, "R11");
        wbyte(8'h12, "R11");
        do_stop("R11");
        held_v = 1; held_r = 8'h12;
        rd(1, 8'h44, 8'h00, "R11");

        // R11: unexpected STOP inside a read byte
        wr_reg(8'h34);
        do_start("R11");
        wbyte(ADDR_R, "R11");
        for (int i = 0; i < 3; i++) slot(1'b1, 1'b1, 1'b1, 1'b1, "R11");
        do_stop("R11");
        held_v = 0;
        wr_reg(8'h12); rd(1, 8'h81, 8'h00, "R11");

        // R10: fill the table, then one load too many
        for (int i = 0; i < 15; i++) load(8'h20 + 8'(i), 8'hB0 + 8'(i));
        load(8'h77, 8'hEE);
        wr_reg(8'h77); rd(1, 8'h66, 8'h00, "R10");
        wr_reg(8'h2E); rd(1, 8'h66, 8'h00, "R10");

        tick(20);
        done = 1;
        report();
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end
endmodule